// File: doc/BRIEF.md
# Closed-Loop Single-Bit Clock Domain Crossing

This block carries one-bit events from a fast source clock to a slower destination clock that bears no phase or frequency relation to it. The source issues a one-cycle send strobe. The block turns that strobe into a request level and holds it. The destination synchronizes the level and reports a one-cycle receive pulse. The synchronized level then travels back to the source as an acknowledge.

The request is not released until the acknowledge has come back. The acknowledge must then fall again before a new event is taken. Because of this four-phase loop, no event is lost, however short the strobe and however slow the destination clock. While a transfer is in flight the source sees a busy flag, and strobes sent during that time are ignored. A one-cycle done pulse marks the end of each transfer.

Top module: `xclk_event_bridge`

## Requirements
- R1: With both resets asserted (active low, asynchronous) and then released, busy_o, done_o, level_o and recv_pulse_o are all 0.
- R2: A send_i strobe sampled on a src_clk edge while busy_o is 0 is accepted, and busy_o is 1 from the next src_clk cycle until the transfer completes.
- R3: A send_i strobe sampled while busy_o is 1 has no effect: it produces no extra receive pulse and no extra done pulse.
- R4: Every accepted send produces exactly one recv_pulse_o, which is high for exactly one dst_clk cycle.
- R5: Every accepted send produces exactly one done_o pulse, which is high for exactly one src_clk cycle, and busy_o is 0 in that cycle.
- R6: level_o is the request level after the destination synchronizer. It is 1 during a receive pulse and in the dst_clk cycle after it, and it is 0 once the block is idle.
- R7: A send strobe that lasts a single src_clk cycle is delivered, with src_clk more than five times faster than dst_clk.
- R8: The internal request stays high until the returned acknowledge is high, and stays low until the acknowledge is low. Consequently the receive pulse of a transfer comes before its done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source (fast) clock |
| src_rst_n | input | 1 | Source asynchronous reset, active low |
| send_i | input | 1 | Send strobe, source domain |
| busy_o | output | 1 | Transfer in flight, source domain |
| done_o | output | 1 | One-cycle completion pulse, source domain |
| dst_clk | input | 1 | Destination (slow) clock |
| dst_rst_n | input | 1 | Destination asynchronous reset, active low |
| level_o | output | 1 | Synchronized request level, destination domain |
| recv_pulse_o | output | 1 | One-cycle receive pulse, destination domain |

## Verification
The assertions assume that each domain's reset is released cleanly with respect to its own clock. They also assume the destination clock is not so fast that the request falls before the destination has held it high for a cycle, which the four-phase loop guarantees for any ratio. The stimulus drives send_i only on source clock falling edges. Bursts of one to three strobe cycles are separated by random gaps, so many strobes land while busy_o is high. The clock periods are 3 ns and 17 ns, so edges drift against each other throughout the run.

// File: rtl/xeb_pkg.sv
package xeb_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_RAISE = 2'd1,
        SRC_LOWER = 2'd2
    } src_state_e;

    typedef struct packed {
        src_state_e state;
        logic       req;
        logic       done;
    } src_regs_t;

    typedef struct packed {
        logic seen;
    } dst_regs_t;

    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/xeb_sync.sv
module xeb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int N = (STAGES < xeb_pkg::MIN_SYNC_STAGES) ?
                       xeb_pkg::MIN_SYNC_STAGES : STAGES;

    logic [N-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[N-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[N-1];

endmodule

// File: rtl/xeb_src_ctrl.sv
module xeb_src_ctrl
    import xeb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic send_i,
    input  logic ack_i,
    output logic req_o,
    output logic busy_o,
    output logic done_o
);
    src_regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        case (regs_q.state)
            SRC_IDLE: begin
                if (send_i) begin
                    regs_d.state = SRC_RAISE;
                    regs_d.req   = 1'b1;
                end
            end
            SRC_RAISE: begin
                if (ack_i) begin
                    regs_d.state = SRC_LOWER;
                    regs_d.req   = 1'b0;
                end
            end
            SRC_LOWER: begin
                if (!ack_i) begin
                    regs_d.state = SRC_IDLE;
                    regs_d.done  = 1'b1;
                end
            end
            default: begin
                regs_d.state = SRC_IDLE;
                regs_d.req   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: SRC_IDLE, req: 1'b0, done: 1'b0};
        else        regs_q <= regs_d;
    end

    assign req_o  = regs_q.req;
    assign busy_o = (regs_q.state != SRC_IDLE);
    assign done_o = regs_q.done;

    // R8: request held high until the acknowledge returns high
    a_r8_req_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);
    // R8: no new request while the acknowledge is still high
    a_r8_req_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && ack_i) |=> !req_o);
    // R2: accepted strobe raises busy
    a_r2_busy_after_send: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && send_i) |=> busy_o);
    // R3: strobes during a raised request do not end the transfer
    a_r3_busy_ignores_send: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> busy_o);
    // R5: done lasts one cycle and is seen with busy low
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: rtl/xeb_dst_edge.sv
module xeb_dst_edge
    import xeb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);
    dst_regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        regs_d.seen = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{seen: 1'b0};
        else        regs_q <= regs_d;
    end

    assign pulse_o = level_i & ~regs_q.seen;

    // R4: receive pulse lasts a single cycle
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    // R6: level stays high in the cycle after the pulse
    a_r6_level_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> level_i);

endmodule

// File: rtl/xclk_event_bridge.sv
module xclk_event_bridge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic send_i,
    output logic busy_o,
    output logic done_o,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic level_o,
    output logic recv_pulse_o
);
    logic req_src;
    logic level_dst;
    logic ack_src;

    xeb_src_ctrl u_src (
        .clk    (src_clk),
        .rst_n  (src_rst_n),
        .send_i (send_i),
        .ack_i  (ack_src),
        .req_o  (req_src),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    xeb_sync #(.STAGES(SYNC_STAGES)) u_fwd_sync (
        .clk     (dst_clk),
        .rst_n   (dst_rst_n),
        .async_i (req_src),
        .sync_o  (level_dst)
    );

    xeb_dst_edge u_dst (
        .clk     (dst_clk),
        .rst_n   (dst_rst_n),
        .level_i (level_dst),
        .pulse_o (recv_pulse_o)
    );

    xeb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (src_clk),
        .rst_n   (src_rst_n),
        .async_i (level_dst),
        .sync_o  (ack_src)
    );

    assign level_o = level_dst;

endmodule

// File: tb/xclk_event_bridge_tb.sv
`timescale 1ns/100ps
module xclk_event_bridge_tb_top;
    localparam realtime SRC_PERIOD = 3.0;
    localparam realtime DST_PERIOD = 17.0;
    localparam int      WATCHDOG   = 100000;
    localparam int      N_BURSTS   = 60;

    logic src_clk = 1'b0, dst_clk = 1'b0;
    logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
    logic send_i = 1'b0;
    logic busy_o, done_o, level_o, recv_pulse_o;

    int checks = 0, errors = 0;
    int accepted = 0, recv_count = 0, done_count = 0;
    bit prev_recv = 1'b0, prev_done = 1'b0;

    always #(SRC_PERIOD/2) src_clk = ~src_clk;
    always #(DST_PERIOD/2) dst_clk = ~dst_clk;

    xclk_event_bridge dut_i (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .send_i(send_i),
        .busy_o(busy_o), .done_o(done_o),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .level_o(level_o), .recv_pulse_o(recv_pulse_o)
    );

    function automatic bit expect_accept(input bit busy, input bit send);
        return send && !busy;
    endfunction

    task automatic check_eq(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    // destination monitor
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (recv_pulse_o) begin
                recv_count++;
                check_eq(level_o, 1, "R6 level high during receive pulse");
                if (prev_recv) check_eq(1, 0, "R4 receive pulse longer than one cycle");
            end
            prev_recv = recv_pulse_o;
        end
    end

    // source monitor
    always @(negedge src_clk) begin
        if (src_rst_n) begin
            if (done_o) begin
                done_count++;
                check_eq(busy_o, 0, "R5 busy low in done cycle");
                check_eq(int'(recv_count >= done_count), 1, "R8 receive before done");
                if (prev_done) check_eq(1, 0, "R5 done longer than one cycle");
            end
            prev_done = done_o;
        end
    end

    task automatic drive_send(input int n);
        bit prev_acc = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge src_clk);
            if (prev_acc) check_eq(busy_o, 1, "R2 busy after accepted send");
            prev_acc = expect_accept(busy_o, 1'b1);
            if (prev_acc) accepted++;
            send_i = 1'b1;
        end
        @(negedge src_clk);
        if (prev_acc) check_eq(busy_o, 1, "R2 busy after accepted send");
        send_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge src_clk);
        while (busy_o) @(negedge src_clk);
        repeat (4) @(negedge src_clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge src_clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog actual hung expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r_base, d_base, gap, len;
        void'($urandom(32'h5EED_0C1C));
        #20 src_rst_n = 1'b1;
        #23 dst_rst_n = 1'b1;
        repeat (3) @(negedge dst_clk);
        // R1 reset state
        check_eq(busy_o, 0, "R1 busy after reset");
        check_eq(done_o, 0, "R1 done after reset");
        check_eq(level_o, 0, "R1 level after reset");
        check_eq(recv_pulse_o, 0, "R1 receive pulse after reset");

        // R7 single-cycle strobe is delivered
        r_base = recv_count; d_base = done_count;
        drive_send(1);
        wait_idle();
        check_eq(recv_count - r_base, 1, "R7 single strobe received");
        check_eq(done_count - d_base, 1, "R7 single strobe completed");

        // R3 strobes while busy are ignored
        r_base = recv_count; d_base = done_count;
        drive_send(1);
        repeat (5) @(negedge src_clk);
        drive_send(4);
        repeat (3) @(negedge src_clk);
        drive_send(1);
        wait_idle();
        check_eq(recv_count - r_base, 1, "R3 extra receive from ignored strobe");
        check_eq(done_count - d_base, 1, "R3 extra done from ignored strobe");

        // random bursts
        for (int b = 0; b < N_BURSTS; b++) begin
            gap = $urandom_range(60, 0);
            len = $urandom_range(3, 1);
            repeat (gap) @(negedge src_clk);
            drive_send(len);
        end
        wait_idle();
        repeat (20) @(negedge src_clk);
        check_eq(recv_count, accepted, "R4 receive pulses per accepted send");
        check_eq(done_count, accepted, "R5 done pulses per accepted send");
        check_eq(level_o, 0, "R6 level low when idle");
        check_eq(busy_o, 0, "R2 busy low when idle");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule